// File: doc/BRIEF.md
# Microprocessor bus address decoder

This block sits between an 8-bit processor with a 16-bit address bus and its memories and peripheral. It splits the address space into a 32 KiB ROM in the upper half, a 16 KiB RAM at the bottom, and an 8 KiB peripheral window. From the top address bits it produces the chip enables and selects that those devices need. The ROM receives a 15-bit offset, so the processor's reset vector pair lands at the end of the ROM image.

The RAM chip select is allowed low only while the phase-2 clock is high. At that point the processor's address and read/write lines have settled, so a write cannot land at a stray location while the bus is changing. The RAM output enable comes from address bit 14 alone. When the processor reads an address that no device drives, the block also steers the read-data bus to a fixed idle byte. This covers the 0x4000 to 0x5FFF gap and RAM addresses during the low clock phase.

Top module: `bus_addr_dec`

## Requirements
- R1: `rom_ce_no` is 0 exactly when address bit 15 is 1 (0x8000 to 0xFFFF), at either clock level.
- R2: `rom_addr_o` carries address bits 14..0, so 0x8000 reaches offset 0x0000 and 0xFFFC/0xFFFD reach 0x7FFC/0x7FFD.
- R3: `ram_cs_no` is 0 exactly when address bit 15 is 0 and `phi2_i` is 1. It is 1 whenever `phi2_i` is 0.
- R4: `ram_oe_no` equals address bit 14, so the RAM drives data only in 0x0000 to 0x3FFF.
- R5: `ram_we_no` equals `rw_i`, where `rw_i` = 0 means a write and 1 means a read.
- R6: `periph_cs_no` is 0 exactly when address bit 15 is 0 and bit 14 is 1. `periph_cs_o` equals address bit 13. Both selects are active only over 0x6000 to 0x7FFF.
- R7: For every address and both clock levels, at most one device is enabled to drive data. Those conditions are: ROM (`rom_ce_no`=0), RAM (`ram_cs_no`=0 and `ram_oe_no`=0), and peripheral (`periph_cs_o`=1 and `periph_cs_no`=0).
- R8: `rd_data_o` carries the input bus of the driving device. It is 0xFF when no device drives, which includes 0x4000 to 0x5FFF at any clock level and RAM addresses while `phi2_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| rw_i | input | 1 | Processor read/write, 1 = read, 0 = write |
| phi2_i | input | 1 | Phase-2 bus clock |
| rom_data_i | input | 8 | Data driven by the ROM |
| ram_data_i | input | 8 | Data driven by the RAM |
| periph_data_i | input | 8 | Data driven by the peripheral |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_addr_o | output | 15 | ROM offset |
| ram_cs_no | output | 1 | RAM chip select, active low, clock-qualified |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| periph_cs_o | output | 1 | Peripheral select, active high |
| periph_cs_no | output | 1 | Peripheral select, active low |
| rd_data_o | output | 8 | Read data returned to the processor |

## Verification
The bench sweeps all 65,536 addresses twice, once with `phi2_i` low and once high, and alternates `rw_i` between addresses. This separates clock-qualified selects from pure address decode and exposes any window boundary that is off by one bit. A directed pass then visits the reset vector, the window edges at 0x3FFF/0x4000, 0x5FFF/0x6000 and 0x7FFF/0x8000, and the gap. Those points show whether the ROM offset mapping, the idle byte and the exclusive drive hold exactly where the windows meet. The device data inputs use distinct per-address patterns, so a wrong mux choice cannot match by accident.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    REG_RAM    = 2'd0,
    REG_GAP    = 2'd1,
    REG_PERIPH = 2'd2,
    REG_ROM    = 2'd3
  } region_e;
endpackage

// File: rtl/bus_region_dec.sv
module bus_region_dec
  import bus_dec_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output logic          rom_ce_no,
  output logic          periph_cs_o,
  output logic          periph_cs_no
);
  localparam int unsigned B15 = AW - 1;
  localparam int unsigned B14 = AW - 2;
  localparam int unsigned B13 = AW - 3;

  logic a15, a14, a13;
  assign a15 = addr_i[B15];
  assign a14 = addr_i[B14];
  assign a13 = addr_i[B13];

  assign rom_ce_no    = ~a15;
  assign periph_cs_no = ~(~a15 & a14);
  assign periph_cs_o  = a13;

  always_comb begin
    if (a15)      region_o = REG_ROM;
    else if (!a14) region_o = REG_RAM;
    else if (a13) region_o = REG_PERIPH;
    else          region_o = REG_GAP;
  end

  // peripheral fully selected only inside its window
  always_comb begin
    if (periph_cs_o && !periph_cs_no)
      p_periph_window_r6: assert (region_o == REG_PERIPH)
        else $error("peripheral selected outside window");
  end
endmodule

// File: rtl/bus_ram_strobe.sv
module bus_ram_strobe (
  input  logic a15_i,
  input  logic a14_i,
  input  logic phi2_i,
  input  logic rw_i,
  output logic ram_cs_no,
  output logic ram_oe_no,
  output logic ram_we_no
);
  // select only in the stable half of the bus cycle
  assign ram_cs_no = ~(~a15_i & phi2_i);
  assign ram_oe_no = a14_i;
  assign ram_we_no = rw_i;

  always_comb begin
    if (!phi2_i)
      p_ram_cs_gated_r3: assert (ram_cs_no)
        else $error("RAM selected in low clock phase");
  end
endmodule

// File: rtl/bus_rd_mux.sv
module bus_rd_mux #(
  parameter int unsigned            DW     = 8,
  parameter int unsigned            NSRC   = 3,
  parameter logic [DW-1:0]          IDLE_V = '1
) (
  input  logic [NSRC-1:0]        drive_i,
  input  logic [NSRC-1:0][DW-1:0] data_i,
  output logic [DW-1:0]          data_o
);
  logic [NSRC:0][DW-1:0] acc;

  assign acc[0] = '0;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign acc[g+1] = acc[g] | (data_i[g] & {DW{drive_i[g]}});
  end

  assign data_o = (|drive_i) ? acc[NSRC] : IDLE_V;

  always_comb begin
    if (drive_i == '0)
      p_idle_data_r8: assert (data_o == IDLE_V)
        else $error("undriven bus not idle");
  end
endmodule

// File: rtl/bus_addr_dec.sv
module bus_addr_dec
  import bus_dec_pkg::*;
#(
  parameter int unsigned   AW     = ADDR_W,
  parameter int unsigned   DW     = DATA_W,
  parameter logic [DW-1:0] IDLE_V = '1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rw_i,
  input  logic          phi2_i,
  input  logic [DW-1:0] rom_data_i,
  input  logic [DW-1:0] ram_data_i,
  input  logic [DW-1:0] periph_data_i,
  output logic          rom_ce_no,
  output logic [AW-2:0] rom_addr_o,
  output logic          ram_cs_no,
  output logic          ram_oe_no,
  output logic          ram_we_no,
  output logic          periph_cs_o,
  output logic          periph_cs_no,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned ROM_AW = AW - 1;
  localparam int unsigned NSRC   = 3;

  region_e               region;
  logic [NSRC-1:0]       drive;
  logic [NSRC-1:0][DW-1:0] src_data;

  bus_region_dec #(.AW(AW)) i_region (
    .addr_i      (addr_i),
    .region_o    (region),
    .rom_ce_no   (rom_ce_no),
    .periph_cs_o (periph_cs_o),
    .periph_cs_no(periph_cs_no)
  );

  bus_ram_strobe i_ram_strobe (
    .a15_i    (addr_i[AW-1]),
    .a14_i    (addr_i[AW-2]),
    .phi2_i   (phi2_i),
    .rw_i     (rw_i),
    .ram_cs_no(ram_cs_no),
    .ram_oe_no(ram_oe_no),
    .ram_we_no(ram_we_no)
  );

  assign rom_addr_o = addr_i[ROM_AW-1:0];

  // drive conditions seen by the devices
  assign drive[0]    = ~rom_ce_no;
  assign drive[1]    = ~ram_cs_no & ~ram_oe_no;
  assign drive[2]    = periph_cs_o & ~periph_cs_no;
  assign src_data[0] = rom_data_i;
  assign src_data[1] = ram_data_i;
  assign src_data[2] = periph_data_i;

  bus_rd_mux #(.DW(DW), .NSRC(NSRC), .IDLE_V(IDLE_V)) i_rd_mux (
    .drive_i(drive),
    .data_i (src_data),
    .data_o (rd_data_o)
  );

  always_comb begin
    p_one_driver_r7: assert ($onehot0(drive))
      else $error("more than one device driving");
    p_rom_ram_excl_r1: assert (rom_ce_no || ram_cs_no)
      else $error("ROM and RAM both selected");
    if (region == REG_GAP)
      p_gap_quiet_r8: assert (drive == '0)
        else $error("device driving in gap");
  end
endmodule

// File: tb/test_bus_addr_dec.sv
module test_bus_addr_dec;
  logic        clk = 1'b0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic [7:0]  rom_d, ram_d, per_d;
  logic        rom_ce_n, ram_cs_n, ram_oe_n, ram_we_n, per_cs, per_cs_n;
  logic [14:0] rom_a;
  logic [7:0]  rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  // simple device models
  assign rom_d = rom_a[7:0] ^ {1'b0, rom_a[14:8]};
  assign ram_d = addr[7:0] + 8'h11;
  assign per_d = addr[7:0] ^ 8'hC3;

  bus_addr_dec i_bus_addr_dec (
    .addr_i(addr), .rw_i(rw), .phi2_i(phi2),
    .rom_data_i(rom_d), .ram_data_i(ram_d), .periph_data_i(per_d),
    .rom_ce_no(rom_ce_n), .rom_addr_o(rom_a),
    .ram_cs_no(ram_cs_n), .ram_oe_no(ram_oe_n), .ram_we_no(ram_we_n),
    .periph_cs_o(per_cs), .periph_cs_no(per_cs_n), .rd_data_o(rd)
  );

  task automatic chk(input string req, input int act, input int exp, input int a);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h phi2=%0d actual=%h expected=%h", req, a, phi2, act, exp);
    end
  endtask

  task automatic step(input int a, input bit ph, input bit r);
    int e_rom, e_ram_cs, e_per_n, n_drv, e_rd;
    @(posedge clk);
    #1;
    addr = a[15:0]; phi2 = ph; rw = r;
    #2;
    e_rom    = (a >= 'h8000) ? 0 : 1;
    e_ram_cs = (a < 'h8000 && ph) ? 0 : 1;
    e_per_n  = (a >= 'h4000 && a < 'h8000) ? 0 : 1;
    chk("R1", rom_ce_n, e_rom, a);
    chk("R2", rom_a, a % 32768, a);
    chk("R3", ram_cs_n, e_ram_cs, a);
    chk("R4", ram_oe_n, (a / 16384) % 2, a);
    chk("R5", ram_we_n, r, a);
    chk("R6", per_cs_n, e_per_n, a);
    chk("R6", per_cs, (a / 8192) % 2, a);
    n_drv = 0;
    if (!rom_ce_n) n_drv++;
    if (!ram_cs_n && !ram_oe_n) n_drv++;
    if (per_cs && !per_cs_n) n_drv++;
    chk("R7", n_drv <= 1, 1, a);
    if (a >= 'h8000)                e_rd = ((a % 256) ^ ((a / 256) % 128));
    else if (a >= 'h6000)           e_rd = ((a % 256) ^ 'hC3);
    else if (a < 'h4000 && ph)      e_rd = ((a + 'h11) % 256);
    else                            e_rd = 'hFF;
    chk("R8", rd, e_rd, a);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // directed boundary points, both clock levels
    int pts[12] = '{'h0000, 'h3FFF, 'h4000, 'h5FFF, 'h6000, 'h7FFF,
                    'h8000, 'hFFFC, 'hFFFD, 'hFFFF, 'h0100, 'h6002};
    foreach (pts[i]) begin
      step(pts[i], 1'b0, 1'b1);
      step(pts[i], 1'b1, 1'b0);
    end
    // reset vector offset, R2
    step('hFFFC, 1'b1, 1'b1);
    chk("R2", rom_a, 'h7FFC, 'hFFFC);
    step('hFFFD, 1'b1, 1'b1);
    chk("R2", rom_a, 'h7FFD, 'hFFFD);
    // gap returns idle, R8
    step('h5000, 1'b1, 1'b1);
    chk("R8", rd, 'hFF, 'h5000);
    // full sweeps at both clock levels, R7
    for (int ph = 0; ph < 2; ph++)
      for (int a = 0; a < 65536; a++)
        step(a, ph[0], a[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule